// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects fifteen interrupt and trap requests into a status register and decides which one the core should service next. The sources are a software interrupt, two external pins, a timer, a debug-port interrupt, two serial channels, a parallel port, two coprocessor events and two traps. Each request is held in the status register until the clearing rule of its class removes it. There are three rules: the return from the service routine, a write-one-to-clear to the status register, or a read or write of the source's data register.

A per-source enable mask decides which interrupts may be taken. Traps do not use the mask and outrank all interrupts. When the core can accept an interrupt and nothing is in service, the block raises a one-cycle take pulse together with the vector address of the highest-priority eligible source. From the next cycle until the return, it holds an acknowledge line high and drives a 4-bit code that names the source in service. Only one interrupt is in service at a time. The 4-bit code can be routed onto four shared bit-I/O lines.

Top module: `pvic_top`

## Requirements
- R1: A high bit on `req_i` sets the matching status bit at the next clock edge. If a request and a clear for the same bit arrive in the same cycle, the set wins. The status register reads at `reg_addr`=0, and bit k belongs to source index k.
- R2: After reset, and whenever no source is in service, `svc_ack_o` is 0 and `svc_code_o` is 0x0.
- R3: A take happens when `core_ok_i` is 1, nothing is in service and at least one pending source is eligible. In that cycle `take_o` is 1 and `vector_o` holds the vector of the selected source. From the next cycle `svc_ack_o` is 1 and `svc_code_o` holds that source's code.
- R4: Index, vector and code for each source: 0 software 0x02/0x1; 1 pin0 0x01/0x2; 2 debug-port 0x42/0x8; 3 pin1 0x04/0x9; 4 timer 0x10/0xC; 5 serial2-in 0x14/0xD; 6 serial2-out 0x18/0xE; 7 coproc-ready 0x20/0x1; 8 coproc-overflow 0x24/0x2; 9 serial-in 0x2C/0x3; 10 serial-out 0x30/0x4; 11 parallel-in 0x34/0x5; 12 parallel-out 0x38/0x6; 13 debug trap 0x03/0x0; 14 user trap 0x46/0x7. A higher index has higher priority.
- R5: The enable mask is written and read at `reg_addr`=1, with bit k belonging to source k. An interrupt whose enable bit is 0 is not taken, but it stays latched in the status register.
- R6: The traps (indices 13 and 14) are taken whatever the enable mask holds, and they win over every interrupt.
- R7: Services do not nest. While one source is in service, `take_o` stays 0. A `ret_i` pulse ends the service, and from the next cycle `svc_ack_o` and `svc_code_o` are 0. The pending sources are then arbitrated again by priority.
- R8: The return clears the status bit of the serviced source for indices 0, 1, 3, 4, 7, 8, 13 and 14. It leaves the status bit of a port source (2, 5, 6, 9, 10, 11, 12) set.
- R9: A write to `reg_addr`=0 clears each status bit written as 1, but only for indices 1, 3, 4, 7 and 8. All other status bits are unaffected.
- R10: A pulse on `acc_i[k]` stands for the data-register access of source k. It clears the status bit only for the port sources 2, 5, 6, 9, 10, 11 and 12, and has no effect on the others.
- R11: While `core_ok_i` is 0, no take happens, and pending requests stay pending.
- R12: When `share_sel_n_i` is 0, `bio_o` carries `svc_code_o`. When it is 1, `bio_o` carries `bio_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 15 | Request pulses, one per source index |
| acc_i | input | 15 | Data-register access pulses, one per source index |
| core_ok_i | input | 1 | Core can accept an interrupt this cycle |
| ret_i | input | 1 | Return-from-interrupt pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status, 1 = enable mask |
| reg_wdata | input | 15 | Register write data |
| reg_rdata | output | 15 | Register read data |
| take_o | output | 1 | One-cycle take pulse |
| vector_o | output | 7 | Vector address of the source being taken |
| svc_ack_o | output | 1 | High for the whole service routine |
| svc_code_o | output | 4 | Code of the source in service, 0 when idle |
| share_sel_n_i | input | 1 | Shared-pin select, 0 routes the service code |
| bio_i | input | 4 | Bit-I/O values for the shared lines |
| bio_o | output | 4 | Shared line outputs |

## Verification
The source count and the vector and code tables are fixed, so the bench builds the block with its default widths: a 7-bit vector, a 4-bit code and fifteen sources. At that size every source can be driven on its own and in mixes. The bench can therefore reach every table entry, every pairing of the enable mask with the traps, and each of the three clearing classes. This includes a request arriving while another source is in service and the re-arbitration that follows the return.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int NSRC   = 15;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int VEC_W  = 7;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    CLS_RETONLY, CLS_RETWR, CLS_PORT, CLS_TRAP
  } clr_cls_e;

  function automatic clr_cls_e cls_of(int k);
    case (k)
      0:                  return CLS_RETONLY;
      1, 3, 4, 7, 8:      return CLS_RETWR;
      13, 14:             return CLS_TRAP;
      default:            return CLS_PORT;
    endcase
  endfunction

  function automatic logic [NSRC-1:0] mask_of(clr_cls_e c);
    logic [NSRC-1:0] m;
    m = '0;
    for (int k = 0; k < NSRC; k++) m[k] = (cls_of(k) == c);
    return m;
  endfunction

  localparam logic [NSRC-1:0] TRAP_M = mask_of(CLS_TRAP);
  localparam logic [NSRC-1:0] WR_M   = mask_of(CLS_RETWR);
  localparam logic [NSRC-1:0] PORT_M = mask_of(CLS_PORT);
  localparam logic [NSRC-1:0] RET_M  = ~PORT_M;

  function automatic logic [VEC_W-1:0] vec_of(logic [IDX_W-1:0] k);
    case (k)
      4'd0:  return 7'h02;
      4'd1:  return 7'h01;
      4'd2:  return 7'h42;
      4'd3:  return 7'h04;
      4'd4:  return 7'h10;
      4'd5:  return 7'h14;
      4'd6:  return 7'h18;
      4'd7:  return 7'h20;
      4'd8:  return 7'h24;
      4'd9:  return 7'h2C;
      4'd10: return 7'h30;
      4'd11: return 7'h34;
      4'd12: return 7'h38;
      4'd13: return 7'h03;
      4'd14: return 7'h46;
      default: return 7'h00;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] code_of(logic [IDX_W-1:0] k);
    case (k)
      4'd0:  return 4'h1;
      4'd1:  return 4'h2;
      4'd2:  return 4'h8;
      4'd3:  return 4'h9;
      4'd4:  return 4'hC;
      4'd5:  return 4'hD;
      4'd6:  return 4'hE;
      4'd7:  return 4'h1;
      4'd8:  return 4'h2;
      4'd9:  return 4'h3;
      4'd10: return 4'h4;
      4'd11: return 4'h5;
      4'd12: return 4'h6;
      4'd14: return 4'h7;
      default: return 4'h0;
    endcase
  endfunction
endpackage

// File: rtl/pvic_regs.sv
module pvic_regs
  import pvic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] acc_i,
  input  logic [NSRC-1:0] ret_clr_i,
  input  logic            w1c_we_i,
  input  logic            en_we_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] status_o,
  output logic [NSRC-1:0] enable_o
);
  logic [NSRC-1:0] status_q, status_d, enable_q, enable_d, clr;

  always_comb begin
    clr = (acc_i & PORT_M) | (ret_clr_i & RET_M);
    if (w1c_we_i) clr = clr | (wdata_i & WR_M);
    status_d = (status_q & ~clr) | req_i;
    enable_d = en_we_i ? wdata_i : enable_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;

  AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |=> ((status_q & $past(req_i)) == $past(req_i))); // R1
  AST_PORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_i & status_q & PORT_M) == '0) && (ret_clr_i == '0) && !w1c_we_i
      |=> ((status_q & $past(status_q)) == $past(status_q))); // R10
endmodule

// File: rtl/pvic_arb.sv
module pvic_arb
  import pvic_pkg::*;
(
  input  logic [NSRC-1:0]  status_i,
  input  logic [NSRC-1:0]  enable_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [NSRC-1:0] elig;

  always_comb begin
    elig    = status_i & (enable_i | TRAP_M);
    valid_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (elig[k]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(k);
      end
    end
  end

  always_comb begin
    if (valid_o) AST_PICK_ELIGIBLE: assert (status_i[idx_o]); // R4
  end
endmodule

// File: rtl/pvic_svc.sv
module pvic_svc
  import pvic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              core_ok_i,
  input  logic              ret_i,
  output logic              take_o,
  output logic [VEC_W-1:0]  vector_o,
  output logic              ack_o,
  output logic [CODE_W-1:0] code_o,
  output logic [NSRC-1:0]   ret_clr_o
);
  logic              in_svc_q, in_svc_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              fin;

  always_comb begin
    take_o    = valid_i && core_ok_i && !in_svc_q;
    vector_o  = vec_of(idx_i);
    fin       = ret_i && in_svc_q;
    in_svc_d  = in_svc_q;
    idx_d     = idx_q;
    code_d    = code_q;
    ret_clr_o = '0;
    if (take_o) begin
      in_svc_d = 1'b1;
      idx_d    = idx_i;
      code_d   = code_of(idx_i);
    end else if (fin) begin
      in_svc_d         = 1'b0;
      code_d           = '0;
      ret_clr_o[idx_q] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_svc_q <= 1'b0;
      idx_q    <= '0;
      code_q   <= '0;
    end else begin
      in_svc_q <= in_svc_d;
      idx_q    <= idx_d;
      code_q   <= code_d;
    end
  end

  assign ack_o  = in_svc_q;
  assign code_o = code_q;

  AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !in_svc_q |-> (code_q == '0)); // R2
  AST_ACK_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> ack_o); // R3
  AST_ACK_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && in_svc_q) |=> !ack_o); // R7
  AST_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    in_svc_q |-> !take_o); // R7
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !core_ok_i |-> !take_o); // R11
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_i,
  input  logic [NSRC-1:0]   acc_i,
  input  logic              core_ok_i,
  input  logic              ret_i,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [NSRC-1:0]   reg_wdata,
  output logic [NSRC-1:0]   reg_rdata,
  output logic              take_o,
  output logic [VEC_W-1:0]  vector_o,
  output logic              svc_ack_o,
  output logic [CODE_W-1:0] svc_code_o,
  input  logic              share_sel_n_i,
  input  logic [CODE_W-1:0] bio_i,
  output logic [CODE_W-1:0] bio_o
);
  logic [NSRC-1:0]  status, enable, ret_clr;
  logic             valid;
  logic [IDX_W-1:0] idx;

  pvic_regs u_regs (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .acc_i(acc_i),
    .ret_clr_i(ret_clr), .w1c_we_i(reg_we && !reg_addr),
    .en_we_i(reg_we && reg_addr), .wdata_i(reg_wdata),
    .status_o(status), .enable_o(enable)
  );

  pvic_arb u_arb (
    .status_i(status), .enable_i(enable), .valid_o(valid), .idx_o(idx)
  );

  pvic_svc u_svc (
    .clk(clk), .rst_n(rst_n), .valid_i(valid), .idx_i(idx),
    .core_ok_i(core_ok_i), .ret_i(ret_i), .take_o(take_o),
    .vector_o(vector_o), .ack_o(svc_ack_o), .code_o(svc_code_o),
    .ret_clr_o(ret_clr)
  );

  assign reg_rdata = reg_addr ? enable : status;
  assign bio_o     = share_sel_n_i ? bio_i : svc_code_o;

  AST_TRAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && ((status & TRAP_M) != '0)) |-> (vector_o == 7'h46 || vector_o == 7'h03)); // R6
endmodule

// File: tb/tb_pvic_top.sv
module tb_pvic_top;
  localparam int N = 15;
  logic clk, rst_n, core_ok, ret, we, addr, sel_n;
  logic [N-1:0] req, acc, wdata, rdata;
  logic take, ack;
  logic [6:0] vec;
  logic [3:0] code, bio_in, bio_out;
  int nchk, nerr;

  pvic_top dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .acc_i(acc), .core_ok_i(core_ok),
    .ret_i(ret), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .take_o(take), .vector_o(vec), .svc_ack_o(ack),
    .svc_code_o(code), .share_sel_n_i(sel_n), .bio_i(bio_in), .bio_o(bio_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {enable, request, expected vector, expected code}
  localparam logic [40:0] TBL [16] = '{
    {15'h7FFF, 15'h0001, 7'h02, 4'h1}, {15'h7FFF, 15'h0003, 7'h01, 4'h2},
    {15'h7FFF, 15'h001F, 7'h10, 4'hC}, {15'h7FFF, 15'h1FFF, 7'h38, 4'h6},
    {15'h0000, 15'h4000, 7'h46, 4'h7}, {15'h0000, 15'h2001, 7'h03, 4'h0},
    {15'h0010, 15'h0110, 7'h10, 4'hC}, {15'h7FFF, 15'h0004, 7'h42, 4'h8},
    {15'h0020, 15'h0020, 7'h14, 4'hD}, {15'h0040, 15'h0040, 7'h18, 4'hE},
    {15'h0080, 15'h0080, 7'h20, 4'h1}, {15'h0200, 15'h0200, 7'h2C, 4'h3},
    {15'h0400, 15'h0400, 7'h30, 4'h4}, {15'h0800, 15'h0800, 7'h34, 4'h5},
    {15'h0008, 15'h0008, 7'h04, 4'h9}, {15'h1000, 15'h7FFF, 7'h46, 4'h7}
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; acc = '0; core_ok = 1'b0; ret = 1'b0;
    we = 1'b0; addr = 1'b0; wdata = '0; sel_n = 1'b1; bio_in = 4'h0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [N-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic pulse_req(input logic [N-1:0] r);
    req = r;
    @(negedge clk);
    req = '0;
  endtask

  task automatic rd(input logic a, input string r, input logic [N-1:0] exp);
    addr = a; #2;
    chk(r, rdata, exp);
  endtask

  task automatic do_ret();
    ret = 1'b1;
    @(negedge clk);
    ret = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    nchk = 0; nerr = 0;
    do_reset();
    // R2 reset state
    chk("R2 ack after reset", ack, 0);
    chk("R2 code after reset", code, 0);
    chk("R3 no take after reset", take, 0);
    rd(1'b0, "R1 status after reset", '0);
    rd(1'b1, "R5 enable after reset", '0);

    // R4 R3 R6 table walk
    for (int i = 0; i < 16; i++) begin
      do_reset();
      wr(1'b1, TBL[i][40:26]);
      pulse_req(TBL[i][25:11]);
      core_ok = 1'b1; #2;
      chk($sformatf("R3 take row %0d", i), take, 1);
      chk($sformatf("R4 vector row %0d", i), vec, TBL[i][10:4]);
      @(negedge clk);
      core_ok = 1'b0;
      chk($sformatf("R3 ack row %0d", i), ack, 1);
      chk($sformatf("R4 code row %0d", i), code, TBL[i][3:0]);
      do_ret();
      chk($sformatf("R7 ack end row %0d", i), {ack, code}, 0);
    end

    // R5 masked interrupt stays latched
    do_reset();
    pulse_req(15'h0002);
    core_ok = 1'b1; #2;
    chk("R5 masked not taken", take, 0);
    rd(1'b0, "R5 masked still latched", 15'h0002);
    @(negedge clk);
    wr(1'b1, 15'h0002);
    #2 chk("R5 taken once enabled", {take, vec}, {1'b1, 7'h01});

    // R11 core not ready
    core_ok = 1'b0; #2;
    chk("R11 no take while core busy", take, 0);
    @(negedge clk);
    chk("R11 no ack while core busy", ack, 0);

    // R7 no nesting and re-arbitration; R8 return clears
    wr(1'b1, 15'h7FFF);
    core_ok = 1'b1;
    @(negedge clk);
    chk("R3 pin0 in service", code, 4'h2);
    pulse_req(15'h0008);
    #2 chk("R7 no take while in service", take, 0);
    rd(1'b0, "R7 pin1 latched during service", 15'h000A);
    core_ok = 1'b0;
    do_ret();
    rd(1'b0, "R8 return clears pin0", 15'h0008);
    core_ok = 1'b1; #2;
    chk("R7 re-arbitrated vector", {take, vec}, {1'b1, 7'h04});
    @(negedge clk);
    core_ok = 1'b0;
    do_ret();
    rd(1'b0, "R8 return clears pin1", 15'h0000);

    // R8 port source survives return
    pulse_req(15'h0200);
    core_ok = 1'b1;
    @(negedge clk);
    core_ok = 1'b0;
    chk("R8 serial-in in service", code, 4'h3);
    do_ret();
    rd(1'b0, "R8 port bit survives return", 15'h0200);

    // R9 write-one-to-clear class only
    do_reset();
    pulse_req(15'h7FFF);
    wr(1'b0, 15'h7FFF);
    rd(1'b0, "R9 w1c clears only write class", 15'h7E65);

    // R10 port access clears only port class
    acc = 15'h7FFF;
    @(negedge clk);
    acc = '0;
    rd(1'b0, "R10 access clears port sources", 15'h6001);

    // R1 set wins over clear
    do_reset();
    req = 15'h0002; we = 1'b1; addr = 1'b0; wdata = 15'h0002;
    @(negedge clk);
    req = '0; we = 1'b0; wdata = '0;
    rd(1'b0, "R1 set wins over same-cycle clear", 15'h0002);

    // R12 pin sharing
    bio_in = 4'hA; sel_n = 1'b1; #2;
    chk("R12 bit-io passes through", bio_out, 4'hA);
    sel_n = 1'b0; #2;
    chk("R12 idle code on shared lines", bio_out, 4'h0);
    wr(1'b1, 15'h0002);
    core_ok = 1'b1;
    @(negedge clk);
    core_ok = 1'b0;
    chk("R12 service code on shared lines", bio_out, 4'h2);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule